// File: doc/BRIEF.md
# Memory-Mapped Character Console Port

This block gives a small 32-bit processor a character console through four word-sized registers at the top of its address space. One register pair serves the receive direction: a byte arriving from a keyboard-style source is held until software picks it up. The other pair serves the transmit direction: software hands over one byte at a time, and the block presents it to a display-style sink until the sink acknowledges it.

Software can work in either of two ways. It can poll the ready flag in each control register, or it can set an enable bit and use the interrupt request for that direction. The transmit request drives hardware interrupt level 0 and the receive request drives level 1. The processor bus is a single-cycle request with a registered acknowledge and registered read data. The block acknowledges only the 16-byte window it owns and stays silent for every other address.

Top module: `conport_top`

## Requirements
- R1: A request to any of the four word addresses BASE+0x0 (receive control), BASE+0x4 (receive data), BASE+0x8 (transmit control) or BASE+0xC (transmit data), with BASE = 0xFFFF0000, raises bus_ack on the cycle after the request. A request outside BASE..BASE+0xF never raises bus_ack.
- R2: A request inside the window whose address is not word aligned is acknowledged. A read of such an address returns zero, and a write to it changes nothing.
- R3: When rx_take is high and rx_valid is high at a clock edge, the byte is captured and the receive ready flag (control bit 0) becomes 1. While that flag is 1, rx_take is low and no further byte is taken.
- R4: A read of the receive data register returns the held byte in bits 7:0, with zeros above, and clears the receive ready flag.
- R5: The transmit ready flag (control bit 0) is 1 after reset. It is 0 from an accepted data write until the cycle after tx_ack, and then it returns to 1.
- R6: A write to the transmit data register while transmit ready is 1 raises tx_valid, with tx_byte equal to write-data bits 7:0.
- R7: A write to the transmit data register while transmit ready is 0 is ignored: tx_byte and tx_valid keep their values.
- R8: In each control register, bit 1 is a read/write interrupt enable. Bit 0 is read-only, and writes to it are ignored. All other bits read as zero.
- R9: irq[0] equals transmit ready AND transmit enable. irq[1] equals receive ready AND receive enable.
- R10: After reset, the receive control register reads 0, the transmit control register reads 1, irq is 0, tx_valid is 0 and rx_take is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_ack | output | 1 | Registered acknowledge for in-window accesses |
| bus_rdata | output | DATA_W | Registered read data |
| rx_valid | input | 1 | Source offers a byte |
| rx_byte | input | CHAR_W | Offered byte |
| rx_take | output | 1 | Port can accept a byte this cycle |
| tx_valid | output | 1 | Byte presented to sink |
| tx_byte | output | CHAR_W | Presented byte |
| tx_ack | input | 1 | Sink has consumed the byte |
| irq | output | 2 | bit 0 transmit request, bit 1 receive request |

## Verification
The bench builds the block with its default parameters: a 32-bit address and data path, 8-bit characters and a base of 0xFFFF0000. With these values the window edges (BASE+0xF against BASE+0x10, and an address just below BASE) and the unused upper data bits can be checked directly at the ports. The same settings expose both handshake collisions: a byte offered while the holding register is full, and a data write while a send is outstanding.

// File: rtl/conport_pkg.sv
package conport_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RX_CTRL,
    SEL_RX_DATA,
    SEL_TX_CTRL,
    SEL_TX_DATA,
    SEL_HOLE
  } reg_sel_t;

  localparam int unsigned BIT_READY  = 0;
  localparam int unsigned BIT_ENABLE = 1;
  localparam int unsigned IRQ_TX     = 0;
  localparam int unsigned IRQ_RX     = 1;
endpackage

// File: rtl/conport_decode.sv
module conport_decode
  import conport_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = 32'hFFFF_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);
  localparam int unsigned WIN_LSB = 4;

  logic in_win;
  assign in_win = (addr[ADDR_W-1:WIN_LSB] == BASE[ADDR_W-1:WIN_LSB]);

  always_comb begin
    sel = SEL_NONE;
    if (in_win) begin
      if (addr[1:0] != 2'b00) begin
        sel = SEL_HOLE;
      end else begin
        unique case (addr[3:2])
          2'd0: sel = SEL_RX_CTRL;
          2'd1: sel = SEL_RX_DATA;
          2'd2: sel = SEL_TX_CTRL;
          default: sel = SEL_TX_DATA;
        endcase
      end
    end
  end
endmodule

// File: rtl/conport_rx.sv
module conport_rx #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_byte,
  input  logic              pop,
  input  logic              ie_we,
  input  logic              ie_val,
  output logic              full,
  output logic              ie,
  output logic [CHAR_W-1:0] held,
  output logic              take
);
  assign take = ~full;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      ie   <= 1'b0;
      held <= '0;
    end else begin
      if (ie_we) ie <= ie_val;
      if (in_valid && !full) begin
        full <= 1'b1;
        held <= in_byte;
      end else if (pop) begin
        full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/conport_tx.sv
module conport_tx #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [CHAR_W-1:0] push_byte,
  input  logic              ie_we,
  input  logic              ie_val,
  input  logic              sink_ack,
  output logic              ready,
  output logic              ie,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_byte
);
  assign ready = ~out_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
      ie        <= 1'b0;
    end else begin
      if (ie_we) ie <= ie_val;
      if (out_valid) begin
        if (sink_ack) out_valid <= 1'b0;
      end else if (push) begin
        out_valid <= 1'b1;
        out_byte  <= push_byte;
      end
    end
  end
endmodule

// File: rtl/conport_top.sv
module conport_top
  import conport_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CHAR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_ack,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_byte,
  output logic              rx_take,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_byte,
  input  logic              tx_ack,
  output logic [1:0]        irq
);
  localparam int unsigned PAD_W = DATA_W - CHAR_W;

  reg_sel_t sel;
  logic     rd, wr;
  logic     rx_full, rx_ie, tx_ready, tx_ie;
  logic [CHAR_W-1:0] rx_held;
  logic [DATA_W-1:0] rd_mux;

  conport_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) dec_i (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign rd = bus_req && !bus_we;
  assign wr = bus_req &&  bus_we;

  conport_rx #(.CHAR_W(CHAR_W)) rx_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (rx_valid),
    .in_byte  (rx_byte),
    .pop      (rd && sel == SEL_RX_DATA),
    .ie_we    (wr && sel == SEL_RX_CTRL),
    .ie_val   (bus_wdata[BIT_ENABLE]),
    .full     (rx_full),
    .ie       (rx_ie),
    .held     (rx_held),
    .take     (rx_take)
  );

  conport_tx #(.CHAR_W(CHAR_W)) tx_i (
    .clk       (clk),
    .rst       (rst),
    .push      (wr && sel == SEL_TX_DATA),
    .push_byte (bus_wdata[CHAR_W-1:0]),
    .ie_we     (wr && sel == SEL_TX_CTRL),
    .ie_val    (bus_wdata[BIT_ENABLE]),
    .sink_ack  (tx_ack),
    .ready     (tx_ready),
    .ie        (tx_ie),
    .out_valid (tx_valid),
    .out_byte  (tx_byte)
  );

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_RX_CTRL: begin
        rd_mux[BIT_READY]  = rx_full;
        rd_mux[BIT_ENABLE] = rx_ie;
      end
      SEL_TX_CTRL: begin
        rd_mux[BIT_READY]  = tx_ready;
        rd_mux[BIT_ENABLE] = tx_ie;
      end
      SEL_RX_DATA: rd_mux = {{PAD_W{1'b0}}, rx_held};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= bus_req && (sel != SEL_NONE);
      bus_rdata <= rd ? rd_mux : '0;
    end
  end

  assign irq[IRQ_TX] = tx_ready && tx_ie;
  assign irq[IRQ_RX] = rx_full  && rx_ie;
endmodule

// File: rtl/conport_chk.sv
module conport_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CHAR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 32'hFFFF_0000
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ack,
  input logic              rx_valid,
  input logic              rx_take,
  input logic              tx_valid,
  input logic [CHAR_W-1:0] tx_byte,
  input logic              tx_ack,
  input logic [1:0]        irq
);
  logic outside;
  assign outside = (bus_addr[ADDR_W-1:4] != BASE[ADDR_W-1:4]);

  // R1
  out_of_window_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && outside) |=> !bus_ack);

  // R1
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> $past(bus_req));

  // R3
  single_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_take) |=> !rx_take);

  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ack) |=> (tx_valid && $stable(tx_byte)));

  // R9
  rx_irq_full_chk: assert property (@(posedge clk) disable iff (rst)
    irq[1] |-> !rx_take);

  // R9
  tx_irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    irq[0] |-> !tx_valid);
endmodule

bind conport_top conport_chk #(.ADDR_W(ADDR_W), .CHAR_W(CHAR_W), .BASE(BASE)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .bus_req  (bus_req),
  .bus_addr (bus_addr),
  .bus_ack  (bus_ack),
  .rx_valid (rx_valid),
  .rx_take  (rx_take),
  .tx_valid (tx_valid),
  .tx_byte  (tx_byte),
  .tx_ack   (tx_ack),
  .irq      (irq)
);

// File: tb/conport_tb.sv
`timescale 1ns/1ps
module conport_top_tb_top;
  localparam logic [31:0] RXC = 32'hFFFF_0000;
  localparam logic [31:0] RXD = 32'hFFFF_0004;
  localparam logic [31:0] TXC = 32'hFFFF_0008;
  localparam logic [31:0] TXD = 32'hFFFF_000C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic bus_ack;
  logic [31:0] bus_rdata;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic rx_take, tx_valid, tx_ack = 1'b0;
  logic [7:0] tx_byte;
  logic [1:0] irq;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  conport_top dut_i (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_take(rx_take), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .tx_ack(tx_ack), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                        output logic ack, output logic [31:0] rd);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    ack = bus_ack; rd = bus_rdata;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [31:0] a, input logic [31:0] exp);
    logic ack; logic [31:0] rd;
    access(1'b0, a, '0, ack, rd);
    check({req, " ack"}, {31'b0, ack}, 32'd1);
    check(req, rd, exp);
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    logic ack; logic [31:0] rd;
    access(1'b1, a, d, ack, rd);
  endtask

  task automatic offer(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); tx_ack = 1'b1;
    @(negedge clk); tx_ack = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 irq", {30'b0, irq}, 32'd0);
    check("R10 tx_valid", {31'b0, tx_valid}, 32'd0);
    check("R10 rx_take", {31'b0, rx_take}, 32'd1);
    rd_chk("R10 rx ctrl", RXC, 32'd0);
    rd_chk("R10 tx ctrl", TXC, 32'd1);
  endtask

  task automatic t_decode();
    logic ack; logic [31:0] rd;
    access(1'b0, 32'hFFFF_0010, '0, ack, rd);
    check("R1 above window no ack", {31'b0, ack}, 32'd0);
    access(1'b0, 32'hFFFE_FFFC, '0, ack, rd);
    check("R1 below window no ack", {31'b0, ack}, 32'd0);
    access(1'b0, 32'hFFFF_000F, '0, ack, rd);
    check("R2 hole ack", {31'b0, ack}, 32'd1);
    check("R2 hole reads zero", rd, 32'd0);
    wr(32'hFFFF_0009, 32'hFFFF_FFFF);
    rd_chk("R2 hole write ignored", TXC, 32'd1);
    check("R2 no launch", {31'b0, tx_valid}, 32'd0);
  endtask

  task automatic t_rx();
    wr(RXC, 32'h1);
    rd_chk("R8 ready bit read-only", RXC, 32'd0);
    offer(8'h5A);
    check("R3 take low when full", {31'b0, rx_take}, 32'd0);
    rd_chk("R3 rx ready", RXC, 32'd1);
    offer(8'h33);
    wr(RXC, 32'h2);
    check("R9 rx irq", {30'b0, irq}, 32'b10);
    rd_chk("R8 rx enable readback", RXC, 32'd3);
    rd_chk("R4 rx byte kept over second offer", RXD, 32'h5A);
    check("R9 rx irq cleared", {30'b0, irq}, 32'd0);
    rd_chk("R4 rx ready cleared", RXC, 32'd2);
    check("R3 take high again", {31'b0, rx_take}, 32'd1);
    offer(8'hC7);
    rd_chk("R4 second byte", RXD, 32'hC7);
    wr(RXC, 32'h0);
  endtask

  task automatic t_tx();
    wr(TXD, 32'hABCD_0141);
    check("R6 tx_valid", {31'b0, tx_valid}, 32'd1);
    check("R6 tx_byte", {24'b0, tx_byte}, 32'h41);
    rd_chk("R5 tx busy", TXC, 32'd0);
    wr(TXD, 32'h42);
    check("R7 byte unchanged", {24'b0, tx_byte}, 32'h41);
    check("R7 still valid", {31'b0, tx_valid}, 32'd1);
    pulse_ack();
    check("R5 tx_valid dropped", {31'b0, tx_valid}, 32'd0);
    rd_chk("R5 tx ready again", TXC, 32'd1);
    wr(TXC, 32'h3);
    check("R9 tx irq", {30'b0, irq}, 32'b01);
    rd_chk("R8 tx enable readback", TXC, 32'd3);
    wr(TXD, 32'h7E);
    check("R9 tx irq while busy", {30'b0, irq}, 32'd0);
    check("R6 second byte", {24'b0, tx_byte}, 32'h7E);
    pulse_ack();
    check("R9 tx irq after ack", {30'b0, irq}, 32'b01);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    t_reset();
    t_decode();
    t_rx();
    t_tx();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule